// File: doc/BRIEF.md
# Interrupt Router Register Window

This block is the register front end of an interrupt router with a parameterised number of input pins (24 by default). Software sees only two directly addressed 32-bit locations inside an 8-bit decoded region. One of them is a select register and the other is a data window. The value held in the select register decides what the window reaches. It can reach an identification register, a read-only version register, an arbitration register that mirrors the identification value, or one half of a 64-bit redirection entry. There is one redirection entry per pin.

The block stores the redirection table and drives every entry's fields to the servicing logic as flat per-pin buses. The servicing logic returns per-pin pending-request set and clear strobes. It also returns remote-IRR set and clear strobes. Byte and halfword accesses are converted at the bus edge. A write is zero-extended from its access size, and read data is trimmed to the access size. Two events are reported back as one-cycle pulses that carry a pin index. The first is a write that changes an entry's mask. The second is a write that leaves a level-triggered entry facing a pending request, which raises a service request.

Top module: `irq_win_regs`

## Requirements
- R1: After reset every entry has its mask bit (bit 16) set and all its other bits cleared. The select register, the identification value and the pending-request register are zero, and no read-valid, service or mask-change pulse is driven.
- R2: Address 0x00 holds the select register, which keeps the low 8 bits of a write and reads back zero-extended. A read of any address other than 0x00 and 0x10 returns zero. A write to any such address changes nothing.
- R3: With select 0x01, a window read returns (pin count − 1) in bits 23:16 and the version code in bits 7:0, with all other bits zero. A window write with select 0x01 has no effect.
- R4: With select 0x00, the window accesses a 4-bit identification value in bits 27:24 (other bits read zero). With select 0x02, a read returns the same value and a write is ignored.
- R5: A select value s ≥ 0x10 reaches entry (s − 0x10) >> 1. If s is odd, the window accesses entry bits 63:32. If s is even, it accesses bits 31:0.
- R6: A window read returns all ones in two cases: when the entry index is at or beyond the pin count, and when the select value is 0x03 to 0x0F. A window write in either case is ignored.
- R7: A low-half write replaces bits 31:0 and then forces remote IRR (bit 14) to 0. A high-half write replaces only bits 63:32. Outside a low-half write to that entry, a remote-IRR clear strobe clears the bit, and otherwise a set strobe sets it.
- R8: One cycle after a window write to an in-range entry, a service-request pulse is driven with that entry's index, if and only if two things hold at write time. The entry's trigger bit (bit 15, 1 = level) after the write must be 1, and the pin's pending-request bit must be set.
- R9: One cycle after a low-half write that changes an entry's mask bit, a mask-change pulse is driven with the pin index and the new mask value. No other write raises it.
- R10: Access size codes are 0 = byte, 1 = halfword, 2 and 3 = word. Write data is zero-extended from the low 8 or 16 bits, and read data above the access size reads as zero.
- R11: Read data and a read-valid strobe appear exactly one cycle after a read request. The read-valid strobe is low after any other cycle.
- R12: The field outputs follow the stored entries. The fields are vector [7:0], delivery mode [10:8], destination mode [11], polarity [13], remote IRR [14], trigger [15], mask [16] and destination [63:56].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Offset within the decoded region |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| pend_set | input | PINS | Per-pin pending-request set strobes |
| pend_clr | input | PINS | Per-pin pending-request clear strobes |
| rirr_set | input | PINS | Per-pin remote-IRR set strobes |
| rirr_clr | input | PINS | Per-pin remote-IRR clear strobes |
| ent_vector | output | PINS*8 | Vector field per pin |
| ent_dlv_mode | output | PINS*3 | Delivery mode per pin |
| ent_dest_mode | output | PINS | Destination mode per pin |
| ent_polarity | output | PINS | Polarity per pin |
| ent_rirr | output | PINS | Remote IRR per pin |
| ent_trig | output | PINS | Trigger mode per pin (1 = level) |
| ent_mask | output | PINS | Mask per pin |
| ent_dest | output | PINS*8 | Destination per pin |
| svc_req | output | 1 | Service request pulse |
| svc_idx | output | $clog2(PINS) | Pin index of the service request |
| mask_chg | output | 1 | Mask-change pulse |
| mask_chg_idx | output | $clog2(PINS) | Pin index of the mask change |
| mask_chg_val | output | 1 | New mask value |

## Verification
The assertions check four properties on every cycle:
- A low-half write leaves the entry's remote IRR at zero.
- Each service pulse names a level-triggered, in-range pin.
- Each mask-change pulse agrees with the mask now stored.
- Every read request is answered one cycle later, and byte reads carry no upper bits.

The window mapping, the all-ones result for unreachable selects, the version and identification contents, the zero-extension of narrow writes and the exact conditions under which pulses do or do not appear depend on the whole register model. Only the bench's scenarios can show these, by comparing directed and random access sequences against its own copy of the table.

// File: rtl/irq_win_pkg.sv
package irq_win_pkg;

    // Directly addressed offsets
    localparam logic [7:0] OFF_SEL = 8'h00;
    localparam logic [7:0] OFF_WIN = 8'h10;

    // Select codes
    localparam logic [7:0] SEL_ID       = 8'h00;
    localparam logic [7:0] SEL_VER      = 8'h01;
    localparam logic [7:0] SEL_ARB      = 8'h02;
    localparam logic [7:0] SEL_TBL_BASE = 8'h10;

    // Redirection entry field positions
    localparam int F_VEC_LO  = 0;
    localparam int F_DLV_LO  = 8;
    localparam int F_DMODE   = 11;
    localparam int F_POL     = 13;
    localparam int F_RIRR    = 14;
    localparam int F_TRIG    = 15;
    localparam int F_MASK    = 16;
    localparam int F_DEST_LO = 56;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        K_ID,
        K_VER,
        K_ARB,
        K_ENT,
        K_NONE
    } sel_kind_e;

    // Zero-extend write data from the access size
    function automatic logic [31:0] size_widen(input logic [1:0] sz, input logic [31:0] d);
        case (acc_size_e'(sz))
            SZ_BYTE: size_widen = {24'h0, d[7:0]};
            SZ_HALF: size_widen = {16'h0, d[15:0]};
            default: size_widen = d;
        endcase
    endfunction

endpackage

// File: rtl/irq_win_decode.sv
module irq_win_decode
    import irq_win_pkg::*;
#(
    parameter int PINS = 24,
    parameter int IDXW = $clog2(PINS)
) (
    input  logic [7:0]      sel,
    output sel_kind_e       kind,
    output logic [IDXW-1:0] idx,
    output logic            hi,
    output logic            in_range
);
    logic [7:0] off;
    logic [6:0] full_idx;

    always_comb begin
        off      = sel - SEL_TBL_BASE;
        full_idx = off[7:1];
        hi       = sel[0];
        idx      = full_idx[IDXW-1:0];
        in_range = 1'b0;
        if (sel == SEL_ID)              kind = K_ID;
        else if (sel == SEL_VER)        kind = K_VER;
        else if (sel == SEL_ARB)        kind = K_ARB;
        else if (sel >= SEL_TBL_BASE) begin
            kind     = K_ENT;
            in_range = (32'(full_idx) < PINS);
        end
        else                            kind = K_NONE;
    end
endmodule

// File: rtl/irq_redir_table.sv
module irq_redir_table
    import irq_win_pkg::*;
#(
    parameter int PINS = 24,
    parameter int IDXW = $clog2(PINS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_hi,
    input  logic [IDXW-1:0]    wr_idx,
    input  logic [31:0]        wr_data,
    input  logic [PINS-1:0]    rirr_set,
    input  logic [PINS-1:0]    rirr_clr,
    output logic [PINS*64-1:0] ent_flat,
    output logic               mchg,
    output logic [IDXW-1:0]    mchg_idx,
    output logic               mchg_val
);
    typedef struct packed {
        logic [PINS-1:0][63:0] ent;
        logic                  mchg;
        logic [IDXW-1:0]       midx;
        logic                  mval;
    } tbl_t;

    tbl_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.mchg = 1'b0;
        for (int i = 0; i < PINS; i++) begin
            if (rirr_clr[i])      s_d.ent[i][F_RIRR] = 1'b0;
            else if (rirr_set[i]) s_d.ent[i][F_RIRR] = 1'b1;
            if (wr_en && wr_idx == IDXW'(i)) begin
                if (wr_hi) begin
                    s_d.ent[i][63:32] = wr_data;
                end else begin
                    s_d.ent[i][31:0]   = wr_data;
                    s_d.ent[i][F_RIRR] = 1'b0;
                end
            end
        end
        if (wr_en && !wr_hi && (wr_data[F_MASK] != s_q.ent[wr_idx][F_MASK])) begin
            s_d.mchg = 1'b1;
            s_d.midx = wr_idx;
            s_d.mval = wr_data[F_MASK];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int i = 0; i < PINS; i++) s_q.ent[i][F_MASK] <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign ent_flat = s_q.ent;
    assign mchg     = s_q.mchg;
    assign mchg_idx = s_q.midx;
    assign mchg_val = s_q.mval;

    // R7
    rirr_low_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hi) |=> !s_q.ent[$past(wr_idx)][F_RIRR]);

    // R7
    high_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi && rirr_set == '0 && rirr_clr == '0)
        |=> s_q.ent[$past(wr_idx)][31:0] == $past(s_q.ent[wr_idx][31:0]));
endmodule

// File: rtl/irq_win_regs.sv
module irq_win_regs
    import irq_win_pkg::*;
#(
    parameter int         PINS    = 24,
    parameter logic [7:0] VERSION = 8'h11,
    localparam int        IDXW    = $clog2(PINS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [7:0]         req_addr,
    input  logic [1:0]         req_size,
    input  logic [31:0]        req_wdata,
    output logic               rd_valid,
    output logic [31:0]        rd_data,
    input  logic [PINS-1:0]    pend_set,
    input  logic [PINS-1:0]    pend_clr,
    input  logic [PINS-1:0]    rirr_set,
    input  logic [PINS-1:0]    rirr_clr,
    output logic [PINS*8-1:0]  ent_vector,
    output logic [PINS*3-1:0]  ent_dlv_mode,
    output logic [PINS-1:0]    ent_dest_mode,
    output logic [PINS-1:0]    ent_polarity,
    output logic [PINS-1:0]    ent_rirr,
    output logic [PINS-1:0]    ent_trig,
    output logic [PINS-1:0]    ent_mask,
    output logic [PINS*8-1:0]  ent_dest,
    output logic               svc_req,
    output logic [IDXW-1:0]    svc_idx,
    output logic               mask_chg,
    output logic [IDXW-1:0]    mask_chg_idx,
    output logic               mask_chg_val
);
    localparam logic [7:0] PIN_MAX = 8'(PINS - 1);

    typedef struct packed {
        logic [7:0]      sel;
        logic [3:0]      id;
        logic [PINS-1:0] pend;
        logic            rd_vld;
        logic [31:0]     rd_dat;
        logic            svc;
        logic [IDXW-1:0] svc_idx;
    } regs_t;

    regs_t r_d, r_q;

    sel_kind_e          kind;
    logic [IDXW-1:0]    idx;
    logic               hi;
    logic               in_range;
    logic [31:0]        wdat;
    logic [31:0]        win_val;
    logic [31:0]        raw;
    logic [63:0]        cur_ent;
    logic               tbl_wr;
    logic               new_trig;
    logic [PINS*64-1:0] ent_flat;

    irq_win_decode #(.PINS(PINS), .IDXW(IDXW)) u_dec (
        .sel      (r_q.sel),
        .kind     (kind),
        .idx      (idx),
        .hi       (hi),
        .in_range (in_range)
    );

    irq_redir_table #(.PINS(PINS), .IDXW(IDXW)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr),
        .wr_hi    (hi),
        .wr_idx   (idx),
        .wr_data  (wdat),
        .rirr_set (rirr_set),
        .rirr_clr (rirr_clr),
        .ent_flat (ent_flat),
        .mchg     (mask_chg),
        .mchg_idx (mask_chg_idx),
        .mchg_val (mask_chg_val)
    );

    // Per-pin field fan-out
    for (genvar p = 0; p < PINS; p++) begin : g_fields
        localparam int B = p * 64;
        assign ent_vector[p*8 +: 8]   = ent_flat[B + F_VEC_LO +: 8];
        assign ent_dlv_mode[p*3 +: 3] = ent_flat[B + F_DLV_LO +: 3];
        assign ent_dest_mode[p]       = ent_flat[B + F_DMODE];
        assign ent_polarity[p]        = ent_flat[B + F_POL];
        assign ent_rirr[p]            = ent_flat[B + F_RIRR];
        assign ent_trig[p]            = ent_flat[B + F_TRIG];
        assign ent_mask[p]            = ent_flat[B + F_MASK];
        assign ent_dest[p*8 +: 8]     = ent_flat[B + F_DEST_LO +: 8];
    end

    always_comb begin
        r_d        = r_q;
        r_d.rd_vld = 1'b0;
        r_d.svc    = 1'b0;
        r_d.pend   = (r_q.pend & ~pend_clr) | pend_set;

        wdat     = size_widen(req_size, req_wdata);
        cur_ent  = ent_flat[32'(idx) * 64 +: 64];
        tbl_wr   = 1'b0;
        new_trig = hi ? cur_ent[F_TRIG] : wdat[F_TRIG];

        case (kind)
            K_ID, K_ARB: win_val = {4'h0, r_q.id, 24'h0};
            K_VER:       win_val = {8'h0, PIN_MAX, 8'h0, VERSION};
            K_ENT:       win_val = in_range ? (hi ? cur_ent[63:32] : cur_ent[31:0]) : '1;
            default:     win_val = '1;
        endcase

        case (req_addr)
            OFF_SEL: raw = {24'h0, r_q.sel};
            OFF_WIN: raw = win_val;
            default: raw = '0;
        endcase

        if (req_valid && !req_write) begin
            r_d.rd_vld = 1'b1;
            r_d.rd_dat = size_widen(req_size, raw);
        end

        if (req_valid && req_write) begin
            if (req_addr == OFF_SEL) begin
                r_d.sel = wdat[7:0];
            end else if (req_addr == OFF_WIN) begin
                if (kind == K_ID) r_d.id = wdat[27:24];
                if (kind == K_ENT && in_range) begin
                    tbl_wr = 1'b1;
                    if (new_trig && r_q.pend[idx]) begin
                        r_d.svc     = 1'b1;
                        r_d.svc_idx = idx;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_valid = r_q.rd_vld;
    assign rd_data  = r_q.rd_dat;
    assign svc_req  = r_q.svc;
    assign svc_idx  = r_q.svc_idx;

    // R8
    svc_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> (32'(svc_idx) < PINS) && ent_trig[svc_idx]);

    // R9
    mask_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_chg |-> (32'(mask_chg_idx) < PINS) && (ent_mask[mask_chg_idx] == mask_chg_val));

    // R11
    rd_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    // R11
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);

    // R10
    byte_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == 2'd0) |=> (rd_data[31:8] == 24'h0));
endmodule

// File: tb/tb_irq_win_regs.sv
module tb_irq_win_regs;
    localparam int PINS = 24;
    localparam int IDXW = $clog2(PINS);
    localparam logic [7:0] VER = 8'h11;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               req_valid, req_write;
    logic [7:0]         req_addr;
    logic [1:0]         req_size;
    logic [31:0]        req_wdata;
    logic               rd_valid;
    logic [31:0]        rd_data;
    logic [PINS-1:0]    pend_set, pend_clr, rirr_set, rirr_clr;
    logic [PINS*8-1:0]  ent_vector, ent_dest;
    logic [PINS*3-1:0]  ent_dlv_mode;
    logic [PINS-1:0]    ent_dest_mode, ent_polarity, ent_rirr, ent_trig, ent_mask;
    logic               svc_req, mask_chg, mask_chg_val;
    logic [IDXW-1:0]    svc_idx, mask_chg_idx;

    irq_win_regs #(.PINS(PINS), .VERSION(VER)) dut (.*);

    always #10 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Bench model
    logic [63:0]     m_ent [PINS];
    logic [7:0]      m_sel;
    logic [3:0]      m_id;
    logic [PINS-1:0] m_pend;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] widen(input logic [1:0] sz, input logic [31:0] d);
        if (sz == 2'd0)      return d & 32'h0000_00FF;
        else if (sz == 2'd1) return d & 32'h0000_FFFF;
        else                 return d;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a, input logic [1:0] sz);
        logic [31:0] v;
        int ix;
        if (a == 8'h00) v = {24'h0, m_sel};
        else if (a == 8'h10) begin
            if (m_sel == 8'h00 || m_sel == 8'h02) v = {4'h0, m_id, 24'h0};
            else if (m_sel == 8'h01) v = {8'h0, 8'(PINS - 1), 8'h0, VER};
            else if (m_sel < 8'h10) v = '1;
            else begin
                ix = (int'(m_sel) - 16) >> 1;
                if (ix >= PINS) v = '1;
                else v = m_sel[0] ? m_ent[ix][63:32] : m_ent[ix][31:0];
            end
        end else v = '0;
        return widen(sz, v);
    endfunction

    task automatic idle_inputs();
        req_valid = 0; req_write = 0; req_addr = 0; req_size = 2'd2; req_wdata = 0;
        pend_set = '0; pend_clr = '0; rirr_set = '0; rirr_clr = '0;
    endtask

    // One bus read; at a negedge on entry and exit
    task automatic bus_read(input logic [7:0] a, input logic [1:0] sz, input string tag);
        logic [31:0] e;
        e = exp_read(a, sz);
        req_valid = 1; req_write = 0; req_addr = a; req_size = sz;
        @(posedge clk); @(negedge clk);
        chk(rd_valid === 1'b1 && rd_data === e, tag, {31'h0, rd_valid, rd_data}, {32'h1, e});
        req_valid = 0;
    endtask

    // One bus write with model update and pulse checks
    task automatic bus_write(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d, input string tag);
        logic [31:0] w;
        logic [63:0] old, nw;
        bit e_svc, e_mc;
        int ix;
        w = widen(sz, d);
        e_svc = 0; e_mc = 0; ix = 0; nw = '0;
        if (a == 8'h00) m_sel = w[7:0];
        else if (a == 8'h10) begin
            if (m_sel == 8'h00) m_id = w[27:24];
            else if (m_sel >= 8'h10) begin
                ix = (int'(m_sel) - 16) >> 1;
                if (ix < PINS) begin
                    old = m_ent[ix];
                    nw  = old;
                    if (m_sel[0]) nw[63:32] = w;
                    else begin nw[31:0] = w; nw[14] = 1'b0; end
                    e_mc  = !m_sel[0] && (old[16] != w[16]);
                    e_svc = nw[15] && m_pend[ix];
                    m_ent[ix] = nw;
                end
            end
        end
        req_valid = 1; req_write = 1; req_addr = a; req_size = sz; req_wdata = d;
        @(posedge clk); @(negedge clk);
        req_valid = 0; req_write = 0;
        chk(svc_req === e_svc && (!e_svc || int'(svc_idx) == ix), {tag, " R8 svc"},
            {31'h0, svc_req, 27'h0, svc_idx}, {31'h0, e_svc, ix[31:0]});
        chk(mask_chg === e_mc && (!e_mc || (int'(mask_chg_idx) == ix && mask_chg_val == nw[16])),
            {tag, " R9 mask pulse"}, {31'h0, mask_chg, 31'h0, mask_chg_val}, {31'h0, e_mc, 31'h0, nw[16]});
        chk(rd_valid === 1'b0, {tag, " R11 no rd after write"}, {63'h0, rd_valid}, 64'h0);
    endtask

    task automatic pulse_pend(input logic [PINS-1:0] s, input logic [PINS-1:0] c);
        pend_set = s; pend_clr = c;
        m_pend = (m_pend & ~c) | s;
        @(posedge clk); @(negedge clk);
        pend_set = '0; pend_clr = '0;
    endtask

    task automatic pulse_rirr(input logic [PINS-1:0] s, input logic [PINS-1:0] c);
        rirr_set = s; rirr_clr = c;
        for (int i = 0; i < PINS; i++) begin
            if (c[i]) m_ent[i][14] = 1'b0;
            else if (s[i]) m_ent[i][14] = 1'b1;
        end
        @(posedge clk); @(negedge clk);
        rirr_set = '0; rirr_clr = '0;
    endtask

    // R12: compare every field output with the model
    task automatic check_fields(input string tag);
        bit ok;
        ok = 1;
        for (int i = 0; i < PINS; i++) begin
            if (ent_vector[i*8 +: 8] !== m_ent[i][7:0]) ok = 0;
            if (ent_dlv_mode[i*3 +: 3] !== m_ent[i][10:8]) ok = 0;
            if (ent_dest_mode[i] !== m_ent[i][11]) ok = 0;
            if (ent_polarity[i] !== m_ent[i][13]) ok = 0;
            if (ent_rirr[i] !== m_ent[i][14]) ok = 0;
            if (ent_trig[i] !== m_ent[i][15]) ok = 0;
            if (ent_mask[i] !== m_ent[i][16]) ok = 0;
            if (ent_dest[i*8 +: 8] !== m_ent[i][63:56]) ok = 0;
        end
        chk(ok, {tag, " R12 fields"}, {40'h0, ent_mask}, {40'h0, {PINS{1'b0}}});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        idle_inputs();
        rst_n = 0;
        m_sel = 0; m_id = 0; m_pend = '0;
        for (int i = 0; i < PINS; i++) m_ent[i] = 64'h0000_0000_0001_0000;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk(ent_mask === {PINS{1'b1}}, "R1 masks set", {40'h0, ent_mask}, {40'h0, {PINS{1'b1}}});
        chk(!rd_valid && !svc_req && !mask_chg, "R1 no pulses", {61'h0, rd_valid, svc_req, mask_chg}, 64'h0);
        check_fields("R1");
        bus_read(8'h00, 2'd2, "R1 select zero");
        bus_read(8'h10, 2'd2, "R1 id zero");

        // R2 select register and stray offsets
        bus_write(8'h00, 2'd2, 32'hABCD_1201, "R2 sel write");
        bus_read(8'h00, 2'd2, "R2 sel readback");
        bus_write(8'h20, 2'd2, 32'h0000_0000, "R2 stray write");
        bus_read(8'h00, 2'd2, "R2 sel unchanged");
        bus_read(8'h20, 2'd2, "R2 stray read zero");
        bus_read(8'h08, 2'd2, "R2 stray read zero 2");

        // R3 version
        bus_read(8'h10, 2'd2, "R3 version");
        chk(exp_read(8'h10, 2'd2) == 32'h0017_0011, "R3 version constant", {32'h0, exp_read(8'h10, 2'd2)}, 64'h0017_0011);
        bus_write(8'h10, 2'd2, 32'hFFFF_FFFF, "R3 version write");
        bus_read(8'h10, 2'd2, "R3 version unchanged");

        // R4 id and arbitration
        bus_write(8'h00, 2'd2, 32'h0, "R4 sel id");
        bus_write(8'h10, 2'd2, 32'hFA00_00FF, "R4 id write");
        bus_read(8'h10, 2'd2, "R4 id read");
        bus_write(8'h00, 2'd2, 32'h2, "R4 sel arb");
        bus_read(8'h10, 2'd2, "R4 arb mirrors id");
        bus_write(8'h10, 2'd2, 32'h0500_0000, "R4 arb write");
        bus_write(8'h00, 2'd2, 32'h0, "R4 sel id again");
        bus_read(8'h10, 2'd2, "R4 id kept after arb write");

        // R10 narrow accesses
        bus_read(8'h10, 2'd0, "R10 byte read id");
        bus_write(8'h10, 2'd0, 32'hFFFF_FFFF, "R10 byte write id");
        bus_read(8'h10, 2'd2, "R10 id zero-extended");
        bus_write(8'h00, 2'd1, 32'h5555_1234, "R10 half write sel");
        bus_read(8'h00, 2'd2, "R10 sel from half");

        // R5 / R6 mapping and out of range
        bus_write(8'h00, 2'd2, 32'h1E, "R5 sel entry7 lo");
        bus_write(8'h10, 2'd2, 32'h0000_0542, "R5 entry7 lo");
        bus_write(8'h00, 2'd2, 32'h1F, "R5 sel entry7 hi");
        bus_write(8'h10, 2'd2, 32'h9C00_0000, "R5 entry7 hi");
        bus_read(8'h10, 2'd2, "R5 entry7 hi read");
        check_fields("R5");
        bus_write(8'h00, 2'd2, 32'h40, "R6 sel beyond");
        bus_read(8'h10, 2'd2, "R6 beyond reads ones");
        bus_write(8'h10, 2'd2, 32'h0, "R6 beyond write");
        check_fields("R6");
        bus_write(8'h00, 2'd2, 32'h05, "R6 sel gap");
        bus_read(8'h10, 2'd2, "R6 gap reads ones");

        // R7 remote IRR
        pulse_rirr(24'h000008, 24'h0);
        chk(ent_rirr[3] === 1'b1, "R7 rirr set", {63'h0, ent_rirr[3]}, 64'h1);
        bus_write(8'h00, 2'd2, 32'h17, "R7 sel entry3 hi");
        bus_write(8'h10, 2'd2, 32'h1200_0000, "R7 hi write");
        chk(ent_rirr[3] === 1'b1, "R7 rirr kept by hi", {63'h0, ent_rirr[3]}, 64'h1);
        bus_write(8'h00, 2'd2, 32'h16, "R7 sel entry3 lo");
        bus_write(8'h10, 2'd2, 32'h0001_4033, "R7 lo write");
        chk(ent_rirr[3] === 1'b0, "R7 rirr cleared by lo", {63'h0, ent_rirr[3]}, 64'h0);
        bus_read(8'h10, 2'd2, "R7 lo read");
        pulse_rirr(24'h000008, 24'h0);
        pulse_rirr(24'h000008, 24'h000008);
        chk(ent_rirr[3] === 1'b0, "R7 clr beats set", {63'h0, ent_rirr[3]}, 64'h0);

        // R8 service request and R9 mask change
        pulse_pend(24'h000020, 24'h0);
        bus_write(8'h00, 2'd2, 32'h1A, "R8 sel entry5 lo");
        bus_write(8'h10, 2'd2, 32'h0000_8031, "R8 level pending");
        bus_write(8'h10, 2'd2, 32'h0000_0031, "R8 edge pending");
        bus_write(8'h00, 2'd2, 32'h1B, "R8 sel entry5 hi");
        bus_write(8'h10, 2'd2, 32'h0100_0000, "R8 hi write edge");
        pulse_pend(24'h0, 24'h000020);
        bus_write(8'h00, 2'd2, 32'h1A, "R8 sel entry5 lo 2");
        bus_write(8'h10, 2'd2, 32'h0001_8031, "R8 level not pending");
        bus_write(8'h10, 2'd2, 32'h0001_8031, "R9 same mask");
        check_fields("R9");

        // Random mix
        for (int n = 0; n < 800; n++) begin
            int op;
            logic [1:0] sz;
            op = int'($urandom_range(0, 9));
            sz = 2'($urandom_range(0, 3));
            if (op == 0) bus_write(8'h00, 2'd2, (($urandom_range(0, 7) == 0) ? $urandom : 32'($urandom_range(0, 8'h44))), "R5 rnd sel");
            else if (op <= 3) bus_write(8'h10, sz, $urandom, "R5 rnd win write");
            else if (op <= 6) bus_read(8'h10, sz, "R5 rnd win read");
            else if (op == 7) bus_read(8'h00, sz, "R2 rnd sel read");
            else if (op == 8) pulse_pend(PINS'($urandom), PINS'($urandom));
            else pulse_rirr(PINS'($urandom), PINS'($urandom));
            if (n % 50 == 0) check_fields("R12 rnd");
        end
        check_fields("R12 final");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule